// File: doc/BRIEF.md
# Water-Level Receive Elastic Buffer

This block is a bit-granular elastic store placed between a line-side payload writer and a PCM-side serial reader. The writer delivers whole bytes and marks the start of each receive frame. The reader pulls one bit per PCM bit-clock enable. The block creates the PCM frame sync itself. On a receiver-rearm command it waits for the next frame marker and then holds the sync off by a programmed number of bit clocks (the water level). That delay is the initial phase offset between the two frame timings, and it is the time the writer has to fill the store before reading begins.

Alignment happens once per rearm. After the first sync both sides run freely: further frame markers and changes to the water level do not move the sync, and the fill level may drift. The fill level is reported so the drift can be watched. The usable depth is the smallest of three bounds: the 185-bit capacity, the number of PCM bits mapped per frame, and the configured payload block length. A write that would exceed it is dropped, and a read from an empty store returns a 1. Each of these events sets a sticky flag.

The alignment controller has three states. ARMED is entered on reset or rearm, and writes are shut in it. DELAY counts bit clocks down. RUN reads and emits a periodic sync. The transitions are as follows. ARMED goes to DELAY on a marker. ARMED goes straight to RUN on a marker that arrives in a bit clock with a water level of zero. DELAY goes to RUN on the bit clock whose down-count is zero. Any state goes to ARMED on rearm.

Top module: `wl_rx_elastic`

## Requirements
- R1: After rst_n, fill_level is 0, ovf_flag and unf_flag are 0, pcm_sync is 0 and pcm_bit is 1.
- R2: While waiting for the first frame marker after reset or rearm, byte writes are ignored: fill_level stays 0 and ovf_flag is not set.
- R3: Number the bit-clock cycles (bit_en high) from the marker cycle, which is index 0 if it is itself a bit clock. pcm_sync is high in exactly the bit-clock cycle whose index equals wl_cfg. With a bit clock every 4 cycles and the marker on a bit clock, this is 4*wl_cfg cycles after the marker.
- R4: With wl_cfg = 0 and bit_en high in the marker cycle, pcm_sync is high in the marker cycle itself.
- R5: Each accepted byte write raises fill_level by 8 at the next clock edge. Each bit read lowers it by 1.
- R6: Bits leave in write order, each byte most significant bit first. The first bit is on pcm_bit in the initial sync cycle, and the store advances one bit per bit_en once reading is active.
- R7: A bit clock in which reading is active and the store is empty puts 1 on pcm_bit and sets unf_flag at the next edge. unf_flag then stays set until rearm.
- R8: After the initial sync, pcm_sync repeats on every FRAME_BITS-th bit clock (default 48).
- R9: After alignment, frame markers and changes of wl_cfg do not shift pcm_sync. Only rearm re-aligns it.
- R10: The limit is min(185, map_bits, blk_len). A write that would raise fill_level above the limit is dropped, leaving fill_level unchanged, and sets ovf_flag, which stays set until rearm.
- R11: rx_rst_cmd clears fill_level and both flags at the next edge and returns the block to waiting for a marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_rst_cmd | input | 1 | Rearm pulse: clear the store and re-align on the next marker |
| wl_cfg | input | 8 | Water level, in PCM bit clocks from marker to sync |
| map_bits | input | 8 | PCM bits mapped per frame (fill bound) |
| blk_len | input | 8 | Payload block length in bits (fill bound) |
| frm_mark | input | 1 | Master channel receive frame marker |
| wr_valid | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte written, most significant bit leaves first |
| bit_en | input | 1 | PCM bit-clock enable |
| pcm_bit | output | 1 | Serial PCM data, valid in bit_en cycles |
| pcm_sync | output | 1 | PCM frame sync, one cycle wide, on a bit clock |
| ovf_flag | output | 1 | Sticky overflow (write dropped) |
| unf_flag | output | 1 | Sticky underflow (read while empty) |
| fill_level | output | 8 | Bits currently held in the store |

## Verification
pcm_sync and pcm_bit are combinational from the current state and the current bit_en and frm_mark inputs, so they are due in the same cycle as the stimulus. fill_level, ovf_flag and unf_flag are registered and change at the first rising edge after the write, read or rearm. The bench drives every input just after a falling edge and samples 1 ns later. A same-cycle result is therefore read in the cycle it belongs to, and a registered result is read in the cycle after its cause. Sync delays and the sync period are measured by counting cycles and bit clocks from the marker or from the previous sync, and are compared with values derived from wl_cfg and FRAME_BITS.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic [1:0] {
        ALN_ARMED = 2'd0,
        ALN_DELAY = 2'd1,
        ALN_RUN   = 2'd2
    } aln_state_t;
endpackage

// File: rtl/wlb_align.sv
module wlb_align
    import wlb_pkg::*;
#(
    parameter int unsigned LVL_W      = 8,
    parameter int unsigned FRAME_BITS = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm,
    input  logic             frm_mark,
    input  logic             bit_en,
    input  logic [LVL_W-1:0] wl_cfg,
    output logic             sync_pulse,
    output logic             wr_open,
    output logic             rd_active
);
    localparam int unsigned FC_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_BITS - 1);

    aln_state_t       st_q, st_d;
    logic [LVL_W-1:0] dly_q, dly_d;
    logic [FC_W-1:0]  fc_q, fc_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ALN_ARMED;
            dly_q <= '0;
            fc_q  <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
            fc_q  <= fc_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d       = st_q;
        dly_d      = dly_q;
        fc_d       = fc_q;
        sync_pulse = 1'b0;
        wr_open    = 1'b0;
        rd_active  = 1'b0;
        unique case (st_q)
            ALN_ARMED: begin
                if (frm_mark) begin
                    wr_open = 1'b1;
                    if (bit_en) begin
                        if (wl_cfg == '0) begin
                            sync_pulse = 1'b1;
                            rd_active  = 1'b1;
                            fc_d       = '0;
                            st_d       = ALN_RUN;
                        end else begin
                            dly_d = wl_cfg - 1'b1;
                            st_d  = ALN_DELAY;
                        end
                    end else begin
                        dly_d = wl_cfg;
                        st_d  = ALN_DELAY;
                    end
                end
            end
            ALN_DELAY: begin
                wr_open = 1'b1;
                if (bit_en) begin
                    if (dly_q == '0) begin
                        sync_pulse = 1'b1;
                        rd_active  = 1'b1;
                        fc_d       = '0;
                        st_d       = ALN_RUN;
                    end else begin
                        dly_d = dly_q - 1'b1;
                    end
                end
            end
            ALN_RUN: begin
                wr_open   = 1'b1;
                rd_active = 1'b1;
                if (bit_en) begin
                    if (fc_q == FC_LAST) begin
                        sync_pulse = 1'b1;
                        fc_d       = '0;
                    end else begin
                        fc_d = fc_q + 1'b1;
                    end
                end
            end
            default: st_d = ALN_ARMED;
        endcase
        if (rearm) begin
            st_d       = ALN_ARMED;
            dly_d      = '0;
            fc_d       = '0;
            sync_pulse = 1'b0;
            wr_open    = 1'b0;
            rd_active  = 1'b0;
        end
    end

    // R11
    rearm_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (st_q == ALN_ARMED));

    // R9
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ALN_RUN && !rearm) |=> (st_q == ALN_RUN));

    // R3
    sync_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> bit_en);

    // R3
    delay_no_sync_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ALN_DELAY && dly_q != '0) |-> !sync_pulse);
endmodule

// File: rtl/wlb_level.sv
module wlb_level
    import wlb_pkg::*;
#(
    parameter int unsigned CAP_BITS = 185,
    parameter int unsigned LVL_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_open,
    input  logic             wr_valid,
    input  logic             rd_active,
    input  logic             bit_en,
    input  logic [LVL_W-1:0] map_bits,
    input  logic [LVL_W-1:0] blk_len,
    output logic             wr_go,
    output logic             rd_go,
    output logic             empty,
    output logic [LVL_W-1:0] fill,
    output logic             ovf,
    output logic             unf
);
    localparam int unsigned SUM_W = LVL_W + 1;
    localparam logic [LVL_W-1:0] CAP_V = LVL_W'(CAP_BITS);

    logic [LVL_W-1:0] fill_q, lim;
    logic [SUM_W-1:0] after_wr, nxt;
    logic             ovf_q, unf_q, wr_try, rd_try, fits;

    always_comb begin
        lim = CAP_V;
        if (map_bits < lim) lim = map_bits;
        if (blk_len < lim)  lim = blk_len;
    end

    assign after_wr = {1'b0, fill_q} + SUM_W'(BYTE_BITS);
    assign fits     = (after_wr <= {1'b0, lim});
    assign wr_try   = wr_open && wr_valid && !clr;
    assign rd_try   = rd_active && bit_en && !clr;
    assign empty    = (fill_q == '0);
    assign wr_go    = wr_try && fits;
    assign rd_go    = rd_try && !empty;

    always_comb begin
        nxt = {1'b0, fill_q};
        if (wr_go) nxt = nxt + SUM_W'(BYTE_BITS);
        if (rd_go) nxt = nxt - SUM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else if (clr) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            fill_q <= (nxt > {1'b0, CAP_V}) ? CAP_V : nxt[LVL_W-1:0];
            if (wr_try && !fits) ovf_q <= 1'b1;
            if (rd_try && empty) unf_q <= 1'b1;
        end
    end

    assign fill = fill_q;
    assign ovf  = ovf_q;
    assign unf  = unf_q;

    // R10
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CAP_V);

    // R5
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go) |=> (fill_q == $past(fill_q) + LVL_W'(BYTE_BITS)));

    // R7
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !clr) |=> unf_q);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);
endmodule

// File: rtl/wlb_store.sv
module wlb_store
    import wlb_pkg::*;
#(
    parameter int unsigned CAP_BITS = 185
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_go,
    input  logic [BYTE_BITS-1:0] wr_byte,
    input  logic                 rd_go,
    output logic                 head_bit
);
    localparam int unsigned PW = $clog2(CAP_BITS);

    logic [CAP_BITS-1:0] mem;
    logic [PW-1:0]       wp_q, rp_q;

    function automatic logic [PW-1:0] slot(input logic [PW-1:0] base, input int unsigned off);
        logic [PW:0] s;
        s = {1'b0, base} + (PW+1)'(off);
        if (s >= (PW+1)'(CAP_BITS)) s = s - (PW+1)'(CAP_BITS);
        return s[PW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (wr_go && !clr) begin
            for (int i = 0; i < BYTE_BITS; i++) begin
                mem[slot(wp_q, i)] <= wr_byte[BYTE_BITS-1-i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else if (clr) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr_go) wp_q <= slot(wp_q, BYTE_BITS);
            if (rd_go) rp_q <= slot(rp_q, 1);
        end
    end

    assign head_bit = mem[rp_q];

    // R6
    rd_ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rp_q < PW'(CAP_BITS));

    // R6
    rd_ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && !clr) |=> (rp_q != $past(rp_q)));
endmodule

// File: rtl/wl_rx_elastic.sv
module wl_rx_elastic
    import wlb_pkg::*;
#(
    parameter int unsigned CAP_BITS   = 185,
    parameter int unsigned LVL_W      = 8,
    parameter int unsigned FRAME_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_rst_cmd,
    input  logic [LVL_W-1:0]     wl_cfg,
    input  logic [LVL_W-1:0]     map_bits,
    input  logic [LVL_W-1:0]     blk_len,
    input  logic                 frm_mark,
    input  logic                 wr_valid,
    input  logic [BYTE_BITS-1:0] wr_byte,
    input  logic                 bit_en,
    output logic                 pcm_bit,
    output logic                 pcm_sync,
    output logic                 ovf_flag,
    output logic                 unf_flag,
    output logic [LVL_W-1:0]     fill_level
);
    logic sync_pulse, wr_open, rd_active;
    logic wr_go, rd_go, empty, head_bit;

    wlb_align #(.LVL_W(LVL_W), .FRAME_BITS(FRAME_BITS)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .rearm      (rx_rst_cmd),
        .frm_mark   (frm_mark),
        .bit_en     (bit_en),
        .wl_cfg     (wl_cfg),
        .sync_pulse (sync_pulse),
        .wr_open    (wr_open),
        .rd_active  (rd_active)
    );

    wlb_level #(.CAP_BITS(CAP_BITS), .LVL_W(LVL_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_rst_cmd),
        .wr_open   (wr_open),
        .wr_valid  (wr_valid),
        .rd_active (rd_active),
        .bit_en    (bit_en),
        .map_bits  (map_bits),
        .blk_len   (blk_len),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .empty     (empty),
        .fill      (fill_level),
        .ovf       (ovf_flag),
        .unf       (unf_flag)
    );

    wlb_store #(.CAP_BITS(CAP_BITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_rst_cmd),
        .wr_go    (wr_go),
        .wr_byte  (wr_byte),
        .rd_go    (rd_go),
        .head_bit (head_bit)
    );

    assign pcm_sync = sync_pulse;
    assign pcm_bit  = (rd_active && !empty) ? head_bit : 1'b1;

    // R7
    empty_read_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && empty) |-> pcm_bit);
endmodule

// File: tb/wl_rx_elastic_test.sv
`timescale 1ns/1ps
module wl_rx_elastic_test;
    localparam int FB  = 48;
    localparam int DIV = 4;
    // water level, expected cycles from marker to sync (R3)
    localparam int VEC [5][2] = '{'{0, 0}, '{1, 4}, '{3, 12}, '{7, 28}, '{12, 48}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_rst_cmd = 1'b0;
    logic [7:0] wl_cfg = 8'd0;
    logic [7:0] map_bits = 8'd250;
    logic [7:0] blk_len = 8'd250;
    logic       frm_mark = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'd0;
    logic       bit_en = 1'b0;
    logic       pcm_bit, pcm_sync, ovf_flag, unf_flag;
    logic [7:0] fill_level;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit rd_run = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wl_rx_elastic #(.FRAME_BITS(FB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_rst_cmd(rx_rst_cmd), .wl_cfg(wl_cfg),
        .map_bits(map_bits), .blk_len(blk_len), .frm_mark(frm_mark),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .bit_en(bit_en),
        .pcm_bit(pcm_bit), .pcm_sync(pcm_sync), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .fill_level(fill_level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        bit_en     = rd_run && (cyc % DIV == 0);
        frm_mark   = 1'b0;
        wr_valid   = 1'b0;
        rx_rst_cmd = 1'b0;
        #1;
    endtask

    task automatic rearm();
        step();
        rx_rst_cmd = 1'b1;
        step();
    endtask

    task automatic to_bitclk();
        while (((cyc + 1) % DIV) != 0) step();
        step();
    endtask

    task automatic write_burst(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            if (i == 0) frm_mark = 1'b1;
            wr_valid = 1'b1;
            wr_byte  = 8'(i + 1);
        end
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all): actual 200000 cycles expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, bi, bj;
        logic [15:0] got;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 fill", int'(fill_level), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 unf", int'(unf_flag), 0);
        check("R1 sync", int'(pcm_sync), 0);
        check("R1 pcm_bit", int'(pcm_bit), 1);

        // R2 writes before any marker are ignored
        wr_valid = 1'b1; wr_byte = 8'hFF;
        step(); step();
        check("R2 fill", int'(fill_level), 0);
        check("R2 ovf", int'(ovf_flag), 0);

        // R3 / R4 table of water levels
        for (int v = 0; v < 5; v++) begin
            wl_cfg = 8'(VEC[v][0]);
            rearm();
            rd_run = 1'b1;
            to_bitclk();
            frm_mark = 1'b1;
            #1;
            n = 0;
            while (!pcm_sync && n < 400) begin
                step();
                n++;
            end
            if (VEC[v][0] == 0) check("R4 same-cycle sync", n, VEC[v][1]);
            else check("R3 sync delay", n, VEC[v][1]);
        end

        // R5 / R6 data order and fill
        wl_cfg = 8'd2;
        rearm();
        rd_run = 1'b1;
        to_bitclk();
        frm_mark = 1'b1; wr_valid = 1'b1; wr_byte = 8'hA5;
        step();
        wr_valid = 1'b1; wr_byte = 8'h3C;
        step();
        check("R5 fill after two bytes", int'(fill_level), 16);
        n = 0;
        while (!pcm_sync && n < 100) begin
            step();
            n++;
        end
        check("R3 sync delay with data", n, 6);
        got = '0;
        got[15] = pcm_bit;
        for (int k = 1; k < 16; k++) begin
            repeat (DIV) step();
            if (k == 4) begin
                check("R5 fill after four reads", int'(fill_level), 12);
                check("R7 no underflow yet", int'(unf_flag), 0);
            end
            got[15-k] = pcm_bit;
        end
        check("R6 serial order", int'(got), 16'hA53C);

        // R7 empty read
        repeat (DIV) step();
        check("R7 empty pcm_bit", int'(pcm_bit), 1);
        step();
        check("R7 unf set", int'(unf_flag), 1);

        // R8 / R9 periodic sync, unaffected by marker and wl change
        bi = 16;
        n = 0;
        while (n < 2000) begin
            step();
            n++;
            if (bit_en) begin
                bi++;
                if (bi == 20) begin
                    wl_cfg = 8'd5;
                    frm_mark = 1'b1;
                    #1;
                end
                if (pcm_sync) break;
            end
        end
        check("R8 sync period", bi, FB);
        bj = 0;
        n = 0;
        while (n < 2000) begin
            step();
            n++;
            if (bit_en) begin
                bj++;
                if (pcm_sync) break;
            end
        end
        check("R9 sync not re-aligned", bj, FB);
        check("R7 unf sticky", int'(unf_flag), 1);

        // R11 rearm clears and waits for marker
        rearm();
        check("R11 fill cleared", int'(fill_level), 0);
        check("R11 unf cleared", int'(unf_flag), 0);
        check("R11 pcm_bit idle", int'(pcm_bit), 1);
        wr_valid = 1'b1; wr_byte = 8'h55;
        step(); step();
        check("R11 write before marker ignored", int'(fill_level), 0);

        // R10 limits, no reads
        rd_run = 1'b0;
        wl_cfg = 8'd10;
        map_bits = 8'd16; blk_len = 8'd200;
        rearm();
        write_burst(3);
        check("R10 map bound fill", int'(fill_level), 16);
        check("R10 map bound ovf", int'(ovf_flag), 1);
        map_bits = 8'd200; blk_len = 8'd24;
        rearm();
        check("R11 ovf cleared", int'(ovf_flag), 0);
        write_burst(3);
        check("R10 block bound no ovf", int'(ovf_flag), 0);
        write_burst(1);
        check("R10 block bound fill", int'(fill_level), 24);
        check("R10 block bound ovf", int'(ovf_flag), 1);
        map_bits = 8'd250; blk_len = 8'd250;
        rearm();
        write_burst(24);
        check("R10 capacity fill", int'(fill_level), 184);
        check("R10 capacity ovf", int'(ovf_flag), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule